// File: doc/BRIEF.md
# Maskable Interrupt Pending Controller

This block gathers a set of interrupt request lines that arrive with no timing relation to the block clock. It combines them into a single service request for a processor core, together with the index of the source to be serviced. Each line first passes through a synchronizer. Configuration then chooses, per source, whether the line is used as a live level or whether rising transitions are latched into a pending bit. A per-source enable mask decides which requests may reach the core. The sense of the mask bits is fixed by a parameter.

The core drives a strobe on every instruction boundary. The block only re-evaluates its output on such a strobe, so the request and index seen by the core stay constant between boundaries. After the core has taken an edge-latched source, it acknowledges that source by index, which clears that source's pending bit. A narrow write port loads either the mask word or the trigger-mode word in one cycle.

Top module: `irq_pend_ctrl`

## Requirements
- R1: Every raw request line passes through a two-stage synchronizer. A line driven just before a clock edge has no effect on a boundary evaluation made on that same edge.
- R2: A source in level mode (mode bit 0) requests service exactly while its synchronized line is high. The request is gone at the next boundary after the line falls.
- R3: A source in edge mode (mode bit 1) sets its pending bit on a low-to-high transition of its synchronized line. A line that stays high gives only one event, and the line must fall and rise again to set the bit anew.
- R4: An acknowledge with index k clears the pending bit of source k only. The pending bits of all other sources are unchanged.
- R5: A write with cfg_sel=0 loads the mask word and a write with cfg_sel=1 loads the mode word. With MASK_ACTIVE_HIGH=1 a mask bit of 1 enables its source, and with MASK_ACTIVE_HIGH=0 a mask bit of 1 disables it. A disabled source is never presented.
- R6: A rising edge on a disabled edge-mode source still sets its pending bit. The source is presented at the first boundary after it is enabled.
- R7: Among enabled requesting sources, the lowest index wins.
- R8: req_out and req_idx change only on a cycle with boundary high and hold otherwise. req_idx is 0 whenever req_out is 0.
- R9: When a new rising edge and an acknowledge of the same source fall in the same cycle, the pending bit ends up set.
- R10: Reset, synchronous and active low, clears all pending bits, disables every source, puts every source in level mode, and drives req_out=0 and req_idx=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_raw | input | NUM_SRC | Asynchronous request lines, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the mask word, 1 selects the mode word |
| cfg_data | input | NUM_SRC | Configuration write data |
| boundary | input | 1 | Instruction-boundary strobe from the core |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_idx | input | IDX_W | Index of the source being acknowledged |
| req_out | output | 1 | Service request to the core |
| req_idx | output | IDX_W | Index of the presented source |

## Verification
A pending bit stuck high shows up as a request that survives its acknowledge. A lost pending bit shows up as a masked edge that never appears after unmasking. Either fault becomes visible at the very next boundary strobe after the stimulus. A wrong mask or mode word gives a wrong index or a missing request at the first boundary once the synchronizer has settled, which takes about three cycles. A flaw in the output hold shows as req_out or req_idx moving while boundary is low, so the bench changes the inputs across long gaps between strobes and samples in between.

// File: rtl/irq_pkg.sv
// Shared definitions for the interrupt pending controller.
// Assumes: nothing beyond standard SystemVerilog.
package irq_pkg;
    typedef enum logic {
        CFG_MASK = 1'b0,
        CFG_MODE = 1'b1
    } cfg_sel_e;
endpackage

// File: rtl/irq_sync.sv
// Multi-flop synchronizer for a vector of independent request lines.
// Assumes: each bit is treated alone; no bus coherence across bits.
module irq_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);
    logic [WIDTH-1:0] stg [STAGES];

    // shift the raw value through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= '0;
        end else begin
            stg[0] <= d_in;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign q_out = stg[STAGES-1];
endmodule

// File: rtl/irq_src_latch.sv
// Per-source edge detector and pending latch.
// Assumes: sync_in is already in the clk domain; ack_hit is pre-decoded.
module irq_src_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    input  logic edge_mode,
    input  logic ack_hit,
    output logic pend_out
);
    logic prev_q;
    logic rise;

    assign rise = edge_mode && sync_in && !prev_q;

    // remember last synchronized level
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_in;
    end

    // set on rise, clear on ack, set wins
    always_ff @(posedge clk) begin
        if (!rst_n)      pend_out <= 1'b0;
        else if (rise)   pend_out <= 1'b1;
        else if (ack_hit) pend_out <= 1'b0;
    end

    // R9
    rise_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> pend_out);

    // R4
    ack_clears_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_hit && !rise) |=> !pend_out);

    // R3
    held_no_new_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_out && sync_in && prev_q) |=> !pend_out);
endmodule

// File: rtl/irq_prio_pick.sv
// Fixed-priority picker: lowest set index wins.
// Assumes: cand may be all zero; idx is then 0.
module irq_prio_pick #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     cand,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    // scan from the top so the lowest index is taken last
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) idx = IDX_W'(i);
        end
    end

    assign any = |cand;
endmodule

// File: rtl/irq_pend_ctrl.sv
// Interrupt pending controller top: sync, per-source latching, masking,
// fixed priority, boundary-gated output register.
// Assumes: boundary and ack come from the core in the clk domain.
module irq_pend_ctrl
    import irq_pkg::*;
#(
    parameter int NUM_SRC          = 8,
    parameter int SYNC_STAGES      = 2,
    parameter bit MASK_ACTIVE_HIGH = 1'b1,
    localparam int IDX_W           = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_raw,
    input  logic               cfg_we,
    input  logic               cfg_sel,
    input  logic [NUM_SRC-1:0] cfg_data,
    input  logic               boundary,
    input  logic               ack_valid,
    input  logic [IDX_W-1:0]   ack_idx,
    output logic               req_out,
    output logic [IDX_W-1:0]   req_idx
);
    localparam logic [NUM_SRC-1:0] MASK_RST = MASK_ACTIVE_HIGH ? '0 : '1;

    logic [NUM_SRC-1:0] sync_lvl;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] mode_q;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] enabled;
    logic [NUM_SRC-1:0] cand;
    logic               pick_any;
    logic [IDX_W-1:0]   pick_idx;
    cfg_sel_e           sel;

    assign sel = cfg_sel_e'(cfg_sel);

    irq_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .d_in(irq_raw), .q_out(sync_lvl)
    );

    // configuration word writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= MASK_RST;
            mode_q <= '0;
        end else if (cfg_we) begin
            if (sel == CFG_MASK) mask_q <= cfg_data;
            else                 mode_q <= cfg_data;
        end
    end

    assign enabled = MASK_ACTIVE_HIGH ? mask_q : ~mask_q;

    genvar g;
    generate
        for (g = 0; g < NUM_SRC; g++) begin : g_src
            irq_src_latch latch_i (
                .clk      (clk),
                .rst_n    (rst_n),
                .sync_in  (sync_lvl[g]),
                .edge_mode(mode_q[g]),
                .ack_hit  (ack_valid && (ack_idx == IDX_W'(g))),
                .pend_out (pend[g])
            );
            assign cand[g] = enabled[g] && (mode_q[g] ? pend[g] : sync_lvl[g]);
        end
    endgenerate

    irq_prio_pick #(.N(NUM_SRC), .IDX_W(IDX_W)) pick_i (
        .cand(cand), .any(pick_any), .idx(pick_idx)
    );

    // present the winner only on an instruction boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_out <= 1'b0;
            req_idx <= '0;
        end else if (boundary) begin
            req_out <= pick_any;
            req_idx <= pick_idx;
        end
    end

    // R8
    hold_between_bnd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> ($stable(req_out) && $stable(req_idx)));

    // R8
    idle_idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_out |-> (req_idx == '0));

    // R5
    presented_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && pick_any) |=> (req_out && $past(enabled[pick_idx])));
endmodule

// File: tb/irq_pend_ctrl_tb.sv
module irq_pend_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N   = 8;
    localparam int IW  = 3;
    localparam bit MAH = 1'b1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_raw = '0;
    logic          cfg_we = 1'b0;
    logic          cfg_sel = 1'b0;
    logic [N-1:0]  cfg_data = '0;
    logic          boundary = 1'b0;
    logic          ack_valid = 1'b0;
    logic [IW-1:0] ack_idx = '0;
    logic          req_out;
    logic [IW-1:0] req_idx;

    int n_vec = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_pend_ctrl #(.NUM_SRC(N), .SYNC_STAGES(2), .MASK_ACTIVE_HIGH(MAH)) dut_i (
        .clk(clk), .rst_n(rst_n), .irq_raw(irq_raw), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_data(cfg_data), .boundary(boundary),
        .ack_valid(ack_valid), .ack_idx(ack_idx),
        .req_out(req_out), .req_idx(req_idx)
    );

    // fields: raw[19:12] enable[11:4] exp_req[3] exp_idx[2:0], all level mode
    localparam logic [19:0] VECS [0:8] = '{
        {8'h00, 8'hFF, 1'b0, 3'd0},
        {8'h01, 8'hFF, 1'b1, 3'd0},
        {8'h80, 8'hFF, 1'b1, 3'd7},
        {8'hA4, 8'hFF, 1'b1, 3'd2},
        {8'hA4, 8'hFB, 1'b1, 3'd5},
        {8'hA4, 8'h00, 1'b0, 3'd0},
        {8'hFF, 8'h80, 1'b1, 3'd7},
        {8'h18, 8'h10, 1'b1, 3'd4},
        {8'h00, 8'hFF, 1'b0, 3'd0}
    };

    task automatic check(input string tag, input logic er, input logic [IW-1:0] ei);
        n_vec++;
        if (req_out !== er || req_idx !== ei) begin
            n_bad++;
            $display("FAIL %s: req=%0b idx=%0d expected req=%0b idx=%0d",
                     tag, req_out, req_idx, er, ei);
        end
    endtask

    task automatic wcfg(input logic s, input logic [N-1:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_sel = s; cfg_data = d;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic set_en(input logic [N-1:0] en);
        wcfg(1'b0, MAH ? en : ~en);
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic bnd();
        @(negedge clk); boundary = 1'b1;
        @(negedge clk); boundary = 1'b0;
    endtask

    task automatic ack(input logic [IW-1:0] k);
        @(negedge clk); ack_valid = 1'b1; ack_idx = k;
        @(negedge clk); ack_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 reset outputs", 1'b0, 3'd0);
        irq_raw = 8'h01; settle(); bnd();
        check("R10 all sources masked after reset", 1'b0, 3'd0);
        irq_raw = 8'h00;

        // vector table walk, level mode
        for (int v = 0; v < 9; v++) begin
            set_en(VECS[v][11:4]);
            irq_raw = VECS[v][19:12];
            settle(); bnd();
            check($sformatf("R7 R5 R2 vector %0d", v), VECS[v][3], VECS[v][2:0]);
        end

        // R1: line driven just before a boundary edge is not yet seen
        set_en(8'hFF); irq_raw = 8'h00; settle(); bnd();
        @(negedge clk); irq_raw = 8'h04; boundary = 1'b1;
        @(negedge clk); boundary = 1'b0;
        check("R1 synchronizer delay", 1'b0, 3'd0);
        settle(); bnd();
        check("R1 seen after sync", 1'b1, 3'd2);

        // R8 hold between boundaries
        irq_raw = 8'h02; settle();
        check("R8 hold while no boundary", 1'b1, 3'd2);
        bnd();
        check("R8 update on boundary", 1'b1, 3'd1);
        irq_raw = 8'h00; settle();
        check("R8 hold after level drop", 1'b1, 3'd1);
        bnd();
        check("R2 level drop seen", 1'b0, 3'd0);

        // R3 edge mode on source 3
        wcfg(1'b1, 8'h08);
        irq_raw = 8'h08; repeat (3) @(negedge clk); irq_raw = 8'h00;
        settle(); bnd();
        check("R3 edge latched after line low", 1'b1, 3'd3);
        ack(3'd2); settle(); bnd();
        check("R4 ack of other index keeps pend", 1'b1, 3'd3);
        ack(3'd3); settle(); bnd();
        check("R4 ack clears pend", 1'b0, 3'd0);
        irq_raw = 8'h08; settle(); bnd();
        check("R3 held high gives event", 1'b1, 3'd3);
        ack(3'd3); settle(); bnd();
        check("R3 held high no second event", 1'b0, 3'd0);
        irq_raw = 8'h00; settle(); irq_raw = 8'h08; settle(); bnd();
        check("R3 re-arm after low", 1'b1, 3'd3);

        // R9 new rise coincides with ack
        irq_raw = 8'h00; settle();
        @(negedge clk); irq_raw = 8'h08;
        @(negedge clk);
        @(negedge clk); ack_valid = 1'b1; ack_idx = 3'd3;
        @(negedge clk); ack_valid = 1'b0;
        settle(); bnd();
        check("R9 set wins over ack", 1'b1, 3'd3);
        ack(3'd3); irq_raw = 8'h00; settle(); bnd();
        check("R4 cleared after R9", 1'b0, 3'd0);

        // R6 masked edge stays pending
        set_en(8'hF7);
        irq_raw = 8'h08; repeat (3) @(negedge clk); irq_raw = 8'h00;
        settle(); bnd();
        check("R6 masked edge hidden", 1'b0, 3'd0);
        set_en(8'hFF); bnd();
        check("R6 shown after unmask", 1'b1, 3'd3);
        irq_raw = 8'h20; settle(); bnd();
        check("R7 edge pend 3 beats level 5", 1'b1, 3'd3);
        ack(3'd3); settle(); bnd();
        check("R7 level 5 after ack", 1'b1, 3'd5);
        irq_raw = 8'h00; settle(); bnd();
        check("R2 idle at end", 1'b0, 3'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule